// File: doc/BRIEF.md
# Serial Display Command Decoder

This block sits behind a byte-wide serial receiver and feeds a small graphic display controller. Each received byte comes with a valid strobe. A separate select line tells the block what the byte is. When the line is high, the byte is pixel data and goes straight to the display memory write path with its own one-cycle strobe. When the line is low, the byte belongs to the command stream. In that stream an opcode byte sets how many argument bytes follow, from none up to eight.

Once the last argument of a command has arrived, the block updates its configuration outputs. Window opcodes load the column window or the row window, and raise a one-cycle load strobe. The address unit takes that strobe as the signal to jump its current column or row to the new start value. The orientation opcode stores a mode byte, and bit 2 of that byte selects vertical address increment. Analog tuning opcodes are parsed with their correct argument counts and then discarded. Opcodes the decoder does not recognise raise an error pulse, and parsing carries on with the next byte taken as an opcode.

Top module: `disp_cmd_parser`

## Requirements
- R1: After reset, col_first is 0, col_last is 63, row_first is 0, row_last is 79, orient is 0, and no strobe is high.
- R2: A byte with byte_valid high and sel_data high appears on pix_byte, with pix_valid high, exactly one clock later.
- R3: Opcode 0x15, followed by two argument bytes, loads col_first from the first argument modulo 64 and col_last from the second argument modulo 64. win_load pulses for one cycle one clock after the second argument.
- R4: Opcode 0x75, followed by two argument bytes, loads row_first from the first argument modulo 80 and row_last from the second argument modulo 80. win_load pulses for one cycle one clock after the second argument.
- R5: Opcode 0xA0, followed by one argument byte, stores that byte on orient. vert_inc equals bit 2 of orient.
- R6: Each of the opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF consumes exactly one argument byte. The argument changes no output, and the byte after it is treated as an opcode.
- R7: Each of the opcodes 0x84, 0x85, 0x86, 0xA4 to 0xA7, 0xAE, 0xAF and 0xE3 consumes no argument byte, so the next byte is treated as an opcode.
- R8: Opcode 0xB8 consumes exactly eight argument bytes and changes no output.
- R9: Opcode 0xFF completes at once and changes no output.
- R10: Any other opcode pulses cmd_err for one cycle, one clock after it arrives, and the next command byte is treated as an opcode.
- R11: If sel_data is high in any cycle while a command is only partly received, that command is dropped. It never completes, and the next command byte is treated as an opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | A byte is present on byte_in this cycle |
| byte_in | input | 8 | Received byte |
| sel_data | input | 1 | High: pixel data; low: command stream |
| pix_valid | output | 1 | One-cycle strobe for a pixel byte |
| pix_byte | output | 8 | Pixel byte for the display memory |
| win_load | output | 1 | One-cycle strobe: a window was loaded |
| col_first | output | 6 | Column window start |
| col_last | output | 6 | Column window end |
| row_first | output | 7 | Row window start |
| row_last | output | 7 | Row window end |
| orient | output | 8 | Stored orientation byte |
| vert_inc | output | 1 | Vertical address increment selected |
| cmd_err | output | 1 | One-cycle strobe: unknown opcode |

## Verification
Two things can happen in the same cycle: a pixel byte is forwarded, and a half-received command is dropped. Both are triggered by the same high level on sel_data. The bench sends an opcode and part of its arguments, then a data byte, then a command byte. The data byte must appear on pix_byte one clock later. The next command byte must be parsed as a fresh opcode: an unknown value raises cmd_err instead of completing the old window command, and the window outputs do not change. A second case raises sel_data for one cycle with no byte present, and checks that the pending command is still dropped.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;

    // What a fully received command does to the configuration
    typedef enum logic [2:0] {
        ACT_COLS,
        ACT_ROWS,
        ACT_ORIENT,
        ACT_DISCARD,
        ACT_UNKNOWN
    } cmd_act_e;

endpackage

// File: rtl/disp_opc_decode.sv
module disp_opc_decode
    import disp_cmd_pkg::*;
#(
    parameter int ARG_MAX = 8,
    localparam int CNTW = $clog2(ARG_MAX + 1)
) (
    input  logic [7:0]      opcode,
    output cmd_act_e        act,
    output logic [CNTW-1:0] nargs
);

    always_comb begin
        act   = ACT_DISCARD;
        nargs = '0;
        case (opcode)
            8'h15: begin act = ACT_COLS;   nargs = CNTW'(2); end
            8'h75: begin act = ACT_ROWS;   nargs = CNTW'(2); end
            8'hA0: begin act = ACT_ORIENT; nargs = CNTW'(1); end
            8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
            8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF:
                nargs = CNTW'(1);
            8'hB8:
                nargs = CNTW'(ARG_MAX);
            8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
            8'hAE, 8'hAF, 8'hE3, 8'hFF:
                nargs = '0;
            default: act = ACT_UNKNOWN;
        endcase
    end

endmodule

// File: rtl/disp_pix_fwd.sv
module disp_pix_fwd #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_byte,
    output logic          out_valid,
    output logic [DW-1:0] out_byte
);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] dat;
    } pix_st_t;

    pix_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid)
            st_d.dat = in_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_byte  = st_q.dat;

    // R2: the strobe follows an accepted byte by exactly one clock
    assert_pix_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid) |-> (out_valid && out_byte == $past(in_byte)));

endmodule

// File: rtl/disp_cmd_parser.sv
module disp_cmd_parser
    import disp_cmd_pkg::*;
#(
    parameter int COLS    = 64,
    parameter int ROWS    = 80,
    parameter int ARG_MAX = 8,
    localparam int CW   = $clog2(COLS),
    localparam int RW   = $clog2(ROWS),
    localparam int CNTW = $clog2(ARG_MAX + 1),
    localparam int IDXW = $clog2(ARG_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_valid,
    input  logic [7:0]    byte_in,
    input  logic          sel_data,
    output logic          pix_valid,
    output logic [7:0]    pix_byte,
    output logic          win_load,
    output logic [CW-1:0] col_first,
    output logic [CW-1:0] col_last,
    output logic [RW-1:0] row_first,
    output logic [RW-1:0] row_last,
    output logic [7:0]    orient,
    output logic          vert_inc
    ,
    output logic          cmd_err
);

    typedef struct packed {
        logic                      busy;
        cmd_act_e                  act;
        logic [CNTW-1:0]           cnt;
        logic [CNTW-1:0]           need;
        logic [ARG_MAX-1:0][7:0]   args;
        logic [CW-1:0]             cs;
        logic [CW-1:0]             ce;
        logic [RW-1:0]             rs;
        logic [RW-1:0]             re;
        logic [7:0]                orient;
        logic                      win;
        logic                      err;
    } prs_st_t;

    prs_st_t st_d, st_q;

    cmd_act_e        dec_act;
    logic [CNTW-1:0] dec_nargs;
    logic [CNTW-1:0] cnt_inc;

    disp_opc_decode #(.ARG_MAX(ARG_MAX)) u_dec (
        .opcode (byte_in),
        .act    (dec_act),
        .nargs  (dec_nargs)
    );

    disp_pix_fwd #(.DW(8)) u_pix (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (byte_valid && sel_data),
        .in_byte   (byte_in),
        .out_valid (pix_valid),
        .out_byte  (pix_byte)
    );

    function automatic logic [CW-1:0] col_wrap(input logic [7:0] v);
        return CW'(32'(v) % COLS);
    endfunction

    function automatic logic [RW-1:0] row_wrap(input logic [7:0] v);
        return RW'(32'(v) % ROWS);
    endfunction

    assign cnt_inc = st_q.cnt + CNTW'(1);

    always_comb begin
        st_d     = st_q;
        st_d.win = 1'b0;
        st_d.err = 1'b0;
        if (sel_data) begin
            // data mode drops any half-received command
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (byte_valid) begin
            if (!st_q.busy) begin
                if (dec_act == ACT_UNKNOWN) begin
                    st_d.err = 1'b1;
                end else if (dec_nargs != '0) begin
                    st_d.busy = 1'b1;
                    st_d.cnt  = '0;
                    st_d.need = dec_nargs;
                    st_d.act  = dec_act;
                end
            end else begin
                st_d.args[st_q.cnt[IDXW-1:0]] = byte_in;
                st_d.cnt = cnt_inc;
                if (cnt_inc == st_q.need) begin
                    st_d.busy = 1'b0;
                    st_d.cnt  = '0;
                    case (st_q.act)
                        ACT_COLS: begin
                            st_d.cs  = col_wrap(st_q.args[0]);
                            st_d.ce  = col_wrap(byte_in);
                            st_d.win = 1'b1;
                        end
                        ACT_ROWS: begin
                            st_d.rs  = row_wrap(st_q.args[0]);
                            st_d.re  = row_wrap(byte_in);
                            st_d.win = 1'b1;
                        end
                        ACT_ORIENT: st_d.orient = byte_in;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.act    <= ACT_DISCARD;
            st_q.ce     <= CW'(COLS - 1);
            st_q.re     <= RW'(ROWS - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign win_load  = st_q.win;
    assign cmd_err   = st_q.err;
    assign col_first = st_q.cs;
    assign col_last  = st_q.ce;
    assign row_first = st_q.rs;
    assign row_last  = st_q.re;
    assign orient    = st_q.orient;
    assign vert_inc  = st_q.orient[2];

    // R4: row window stays inside the row count
    assert_row_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(row_first) < ROWS) && (32'(row_last) < ROWS));

    // R3: a window load needs opcode plus two arguments, so never back to back
    assert_win_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        win_load |=> !win_load);

    // R11: a window can only load from a command byte seen the cycle before
    assert_win_from_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        win_load |-> ($past(byte_valid) && !$past(sel_data)));

    // R2: while pixel bytes stream, configuration stays put
    assert_cfg_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> ($stable(orient) && $stable(col_first) && $stable(row_first)
                       && !win_load && !cmd_err));

    // R10: the error pulse only follows an opcode byte
    assert_err_from_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> ($past(byte_valid) && !$past(sel_data)));

    // R8: the argument counter stays below the pending count
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt < st_q.need));

endmodule

// File: tb/disp_cmd_parser_test.sv
module disp_cmd_parser_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_in = '0;
    logic       sel_data = 1'b0;
    logic       pix_valid, win_load, vert_inc, cmd_err;
    logic [7:0] pix_byte, orient;
    logic [5:0] col_first, col_last;
    logic [6:0] row_first, row_last;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    disp_cmd_parser uut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
        .sel_data(sel_data), .pix_valid(pix_valid), .pix_byte(pix_byte),
        .win_load(win_load), .col_first(col_first), .col_last(col_last),
        .row_first(row_first), .row_last(row_last), .orient(orient),
        .vert_inc(vert_inc), .cmd_err(cmd_err)
    );

    typedef struct packed {
        logic       sel;
        logic [7:0] dat;
        logic       pix;
        logic       win;
        logic       err;
        logic [5:0] cs;
        logic [5:0] ce;
        logic [6:0] rs;
        logic [6:0] re;
        logic [7:0] rm;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h15, 1'b0, 1'b0, 1'b0, 6'd0, 6'd63, 7'd0, 7'd79, 8'h00},
        '{1'b0, 8'h45, 1'b0, 1'b0, 1'b0, 6'd0, 6'd63, 7'd0, 7'd79, 8'h00},
        '{1'b0, 8'h7F, 1'b0, 1'b1, 1'b0, 6'd5, 6'd63, 7'd0, 7'd79, 8'h00},
        '{1'b0, 8'h75, 1'b0, 1'b0, 1'b0, 6'd5, 6'd63, 7'd0, 7'd79, 8'h00},
        '{1'b0, 8'hF5, 1'b0, 1'b0, 1'b0, 6'd5, 6'd63, 7'd0, 7'd79, 8'h00},
        '{1'b0, 8'hA0, 1'b0, 1'b1, 1'b0, 6'd5, 6'd63, 7'd5, 7'd0, 8'h00},
        '{1'b0, 8'hA0, 1'b0, 1'b0, 1'b0, 6'd5, 6'd63, 7'd5, 7'd0, 8'h00},
        '{1'b0, 8'h04, 1'b0, 1'b0, 1'b0, 6'd5, 6'd63, 7'd5, 7'd0, 8'h04},
        '{1'b1, 8'h3C, 1'b1, 1'b0, 1'b0, 6'd5, 6'd63, 7'd5, 7'd0, 8'h04},
        '{1'b0, 8'hAE, 1'b0, 1'b0, 1'b0, 6'd5, 6'd63, 7'd5, 7'd0, 8'h04},
        '{1'b0, 8'h81, 1'b0, 1'b0, 1'b0, 6'd5, 6'd63, 7'd5, 7'd0, 8'h04},
        '{1'b0, 8'h75, 1'b0, 1'b0, 1'b0, 6'd5, 6'd63, 7'd5, 7'd0, 8'h04},
        '{1'b0, 8'h12, 1'b0, 1'b0, 1'b1, 6'd5, 6'd63, 7'd5, 7'd0, 8'h04},
        '{1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 6'd5, 6'd63, 7'd5, 7'd0, 8'h04},
        '{1'b0, 8'hE3, 1'b0, 1'b0, 1'b0, 6'd5, 6'd63, 7'd5, 7'd0, 8'h04}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive one byte at a falling edge; returns at the next falling edge
    task automatic send(input logic sel, input logic [7:0] b);
        sel_data   = sel;
        byte_in    = b;
        byte_valid = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0;
        sel_data   = 1'b0;
    endtask

    task automatic chk_cfg(input string req, input int cs, input int ce,
                           input int rs, input int re, input int rm);
        chk(req, "col_first", int'(col_first), cs);
        chk(req, "col_last",  int'(col_last),  ce);
        chk(req, "row_first", int'(row_first), rs);
        chk(req, "row_last",  int'(row_last),  re);
        chk(req, "orient",    int'(orient),    rm);
        chk(req, "vert_inc",  int'(vert_inc),  int'(rm[2]));
    endtask

    localparam logic [7:0] ONE_ARG [11] = '{8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
        8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF};
    localparam logic [7:0] NO_ARG [10] = '{8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5,
        8'hA6, 8'hA7, 8'hAE, 8'hAF, 8'hE3};

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "win_load", int'(win_load), 0);
        chk("R1", "pix_valid", int'(pix_valid), 0);
        chk("R1", "cmd_err", int'(cmd_err), 0);
        chk_cfg("R1", 0, 63, 0, 79, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R3 R4 R5 R2 R7 R6 R10 R9
        for (int i = 0; i < NV; i++) begin
            send(VEC[i].sel, VEC[i].dat);
            chk("R2", "pix_valid", int'(pix_valid), int'(VEC[i].pix));
            if (VEC[i].pix) chk("R2", "pix_byte", int'(pix_byte), int'(VEC[i].dat));
            chk("R3", "win_load", int'(win_load), int'(VEC[i].win));
            chk("R10", "cmd_err", int'(cmd_err), int'(VEC[i].err));
            chk_cfg("R4", int'(VEC[i].cs), int'(VEC[i].ce), int'(VEC[i].rs),
                    int'(VEC[i].re), int'(VEC[i].rm));
        end

        // R6: each one-argument opcode swallows 0xA0, so 0xE3 stays an opcode
        for (int i = 0; i < 11; i++) begin
            send(1'b0, ONE_ARG[i]);
            send(1'b0, 8'hA0);
            send(1'b0, 8'hE3);
            chk("R6", "cmd_err", int'(cmd_err), 0);
            chk_cfg("R6", 5, 63, 5, 0, 8'h04);
        end

        // R7: a zero-argument opcode leaves 0xA0 to be parsed as an opcode
        for (int i = 0; i < 10; i++) begin
            send(1'b0, NO_ARG[i]);
            send(1'b0, 8'hA0);
            send(1'b0, 8'(i + 8));
            chk("R7", "orient", int'(orient), i + 8);
        end
        send(1'b0, 8'hA0);
        send(1'b0, 8'h04);

        // R8: eight arguments swallowed, including window opcodes
        send(1'b0, 8'hB8);
        for (int i = 0; i < 8; i++) begin
            send(1'b0, (i % 2 == 0) ? 8'h15 : 8'hA0);
            chk("R8", "win_load", int'(win_load), 0);
        end
        send(1'b0, 8'h15);
        send(1'b0, 8'h02);
        send(1'b0, 8'h43);
        chk("R8", "win_load", int'(win_load), 1);
        chk_cfg("R8", 2, 3, 5, 0, 8'h04);

        // R10: back-to-back unknown opcodes
        send(1'b0, 8'h00);
        chk("R10", "cmd_err first", int'(cmd_err), 1);
        send(1'b0, 8'h01);
        chk("R10", "cmd_err second", int'(cmd_err), 1);
        send(1'b0, 8'hE3);
        chk("R10", "cmd_err clear", int'(cmd_err), 0);

        // R11 with R2: data byte aborts a half command in the same cycle
        send(1'b0, 8'h15);
        send(1'b0, 8'h10);
        send(1'b1, 8'h5A);
        chk("R2", "pix_valid abort", int'(pix_valid), 1);
        chk("R2", "pix_byte abort", int'(pix_byte), 8'h5A);
        send(1'b0, 8'h02);
        chk("R11", "cmd_err after abort", int'(cmd_err), 1);
        chk("R11", "win_load after abort", int'(win_load), 0);
        chk_cfg("R11", 2, 3, 5, 0, 8'h04);

        // R11: select high with no byte still drops the pending command
        send(1'b0, 8'h75);
        send(1'b0, 8'h20);
        sel_data = 1'b1;
        @(negedge clk);
        sel_data = 1'b0;
        chk("R11", "pix_valid idle", int'(pix_valid), 0);
        send(1'b0, 8'hE3);
        chk("R11", "win_load idle abort", int'(win_load), 0);
        chk("R11", "cmd_err idle abort", int'(cmd_err), 0);
        chk_cfg("R11", 2, 3, 5, 0, 8'h04);

        // R4: upper modulo range
        send(1'b0, 8'h75);
        send(1'b0, 8'hFF);
        send(1'b0, 8'h4F);
        chk("R4", "win_load", int'(win_load), 1);
        chk_cfg("R4", 2, 3, 15, 79, 8'h04);

        // R1: reset mid-command returns defaults
        send(1'b0, 8'h15);
        rst_n = 1'b0;
        @(negedge clk);
        chk_cfg("R1", 0, 63, 0, 79, 0);
        rst_n = 1'b1;
        @(negedge clk);
        send(1'b0, 8'h00);
        chk("R1", "cmd_err after reset", int'(cmd_err), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule